// File: doc/BRIEF.md
# Page-Write Buffer With Retriggerable Load Window

This block is a cycle-based behavioural model of the write engine of a byte-wide nonvolatile memory. A host issues single-cycle byte-write strobes, each with an address and a data byte. The engine collects these bytes into a page latch of 64 entries, indexed by the low six address bits. A load window follows every strobe. Each new strobe restarts the window from zero, so the window acts as a retriggerable one-shot. When the window runs out with no further strobe, the engine enters a programming cycle of fixed length. In that cycle it commits every loaded byte of the page to a small internal array.

The block has no ready flag. A host detects completion by reading back the last byte it wrote. While a write cycle is in progress, that read returns bit 7 inverted. Once programming is over, the read returns the true byte. The window length and the programming length are parameters counted in clock cycles, so a bench can make both short. The host read port has one cycle of latency.

Top module: `pgwr_engine`

## Requirements
- R1: After a synchronous reset, `busy` is 0, `rd_valid` is 0 and `rdata` is 0x00.
- R2: The first accepted strobe of a page sets the page from address bits above bit 5. Later strobes in the same load window use only their address bits 5:0 and land in that page, whatever their upper bits are.
- R3: Every accepted strobe restarts the load window. `busy` rises exactly WINDOW_CYC clock edges after the last accepted strobe is sampled, and it stays low as long as strobes keep coming less than WINDOW_CYC cycles apart.
- R4: `busy` stays high for exactly PROG_CYC cycles, whatever number of bytes was loaded (1 to 64).
- R5: Programming writes only the page offsets that were loaded. Other locations in the page keep their earlier contents.
- R6: If one offset is loaded twice in a window, the later byte is the one programmed.
- R7: Write strobes while `busy` is high are ignored. They change neither the array nor the last-written location.
- R8: While the load window or the programming cycle is active, a read of the last written location returns that byte with bit 7 inverted and bits 6:0 unchanged.
- R9: While a write cycle is active, a read of any other location returns 0xFF.
- R10: After `busy` falls, reads return the true stored bytes, and a new page can be started at once.
- R11: `rd_valid` and `rdata` appear on the cycle after `rd_en` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte-write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid when rd_valid is high |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| busy | output | 1 | High during the programming cycle |

## Verification
The bench drives three page patterns.

- A burst of consecutive strobes fills six offsets. This pattern separates correct window timing from an off-by-one, and it checks that a plain commit reads back.
- Strobes spread out with gaps just under the window length show that each strobe restarts the timer. The same pattern loads an offset twice and uses foreign upper address bits on one strobe, which shows last-write-wins and page capture.
- A single byte at the top offset shows that the programming length does not depend on how many bytes were loaded.

Polling reads, foreign-address reads and ignored strobes are placed inside both the window and the programming cycle. The results tell the inverted-bit-7 status apart from the all-ones fill and from true data.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_LOAD = 2'd1,
    PG_PROG = 2'd2
  } pg_state_e;
endpackage

// File: rtl/pgwr_array.sv
module pgwr_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rq
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // write port, no reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read with synchronous output reset
  always_ff @(posedge clk) begin
    if (rst)     rq <= '0;
    else if (re) rq <= mem[raddr];
  end
endmodule

// File: rtl/pgwr_page_latch.sv
module pgwr_page_latch #(
  parameter int PAGE_BITS = 6,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_en,
  input  logic [PAGE_BITS-1:0] ld_idx,
  input  logic [DATA_W-1:0]    ld_data,
  input  logic                 clr,
  input  logic [PAGE_BITS-1:0] rd_idx,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_vld
);
  localparam int PAGE_SIZE = 1 << PAGE_BITS;

  logic [DATA_W-1:0]    lane_data [PAGE_SIZE];
  logic [PAGE_SIZE-1:0] lane_vld;

  for (genvar g = 0; g < PAGE_SIZE; g++) begin : g_lane
    logic [DATA_W-1:0] d_q;
    logic              v_q;
    logic              hit;

    assign hit = ld_en && (ld_idx == PAGE_BITS'(g));

    always_ff @(posedge clk) begin
      if (hit) d_q <= ld_data;
    end

    always_ff @(posedge clk) begin
      if (rst || clr) v_q <= 1'b0;
      else if (hit)   v_q <= 1'b1;
    end

    assign lane_data[g] = d_q;
    assign lane_vld[g]  = v_q;
  end

  assign rd_data = lane_data[rd_idx];
  assign rd_vld  = lane_vld[rd_idx];

  // a cleared page holds no pending bytes
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr && !ld_en |=> lane_vld == '0); // R5
endmodule

// File: rtl/pgwr_sequencer.sv
module pgwr_sequencer
  import pgwr_pkg::*;
#(
  parameter int WINDOW_CYC = 16,
  parameter int PROG_CYC   = 80,
  parameter int PAGE_BITS  = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_en,
  output logic                 in_load,
  output logic                 busy,
  output logic                 commit_en,
  output logic [PAGE_BITS-1:0] commit_idx,
  output logic                 prog_done
);
  localparam int WIN_W = (WINDOW_CYC > 1) ? $clog2(WINDOW_CYC) : 1;
  localparam int PRG_W = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_CYC - 1);
  localparam logic [PRG_W-1:0] PRG_LAST = PRG_W'(PROG_CYC - 1);
  localparam logic [PRG_W:0]   PAGE_LIM = (PRG_W+1)'(1 << PAGE_BITS);

  pg_state_e        state_q;
  logic [WIN_W-1:0] win_q;
  logic [PRG_W-1:0] prg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PG_IDLE;
      win_q   <= '0;
      prg_q   <= '0;
    end else begin
      case (state_q)
        PG_IDLE: begin
          if (ld_en) begin
            state_q <= PG_LOAD;
            win_q   <= '0;
          end
        end
        PG_LOAD: begin
          if (ld_en) begin
            win_q <= '0;
          end else if (win_q == WIN_LAST) begin
            state_q <= PG_PROG;
            prg_q   <= '0;
          end else begin
            win_q <= win_q + 1'b1;
          end
        end
        PG_PROG: begin
          if (prg_q == PRG_LAST) state_q <= PG_IDLE;
          else                   prg_q   <= prg_q + 1'b1;
        end
        default: state_q <= PG_IDLE;
      endcase
    end
  end

  assign in_load    = (state_q == PG_LOAD);
  assign busy       = (state_q == PG_PROG);
  assign commit_en  = busy && ({1'b0, prg_q} < PAGE_LIM);
  assign commit_idx = prg_q[PAGE_BITS-1:0];
  assign prog_done  = busy && (prg_q == PRG_LAST);

  // ---- checker counters, separate from the control path ----
  localparam int QW = $clog2(WINDOW_CYC + 2);
  localparam int BW = $clog2(PROG_CYC + 2);
  localparam logic [QW-1:0] Q_MAX  = QW'(WINDOW_CYC + 1);
  localparam logic [QW-1:0] Q_WIN  = QW'(WINDOW_CYC);
  localparam logic [BW-1:0] B_PROG = BW'(PROG_CYC);

  logic [QW-1:0] quiet_q;
  logic [BW-1:0] brun_q;

  always_ff @(posedge clk) begin
    if (rst || ld_en)        quiet_q <= '0;
    else if (quiet_q != Q_MAX) quiet_q <= quiet_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       brun_q <= '0;
    else if (busy) brun_q <= brun_q + 1'b1;
    else           brun_q <= '0;
  end

  AST_WINDOW_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> quiet_q == Q_WIN); // R3
  AST_PROG_NOT_LONG: assert property (@(posedge clk) disable iff (rst)
    busy |-> brun_q < B_PROG); // R4
  AST_PROG_FULL_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> brun_q == B_PROG); // R4
endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine #(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BITS  = 6,
  parameter int WINDOW_CYC = 16,
  parameter int PROG_CYC   = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rd_valid,
  output logic              busy
);
  localparam int DATA_W = 8;
  localparam int TAG_W  = ADDR_W - PAGE_BITS;

  logic                 in_load, busy_w, commit_en, prog_done;
  logic [PAGE_BITS-1:0] commit_idx;
  logic                 ld_en, cyc_active, last_hit;
  logic [TAG_W-1:0]     page_q;
  logic [PAGE_BITS-1:0] last_off_q;
  logic [DATA_W-1:0]    last_data_q;
  logic [DATA_W-1:0]    lat_data, ram_q, poll_byte_q;
  logic                 lat_vld, arr_we;
  logic                 rd_valid_q, poll_q, blank_q;

  assign ld_en      = wr_en && !busy_w;
  assign cyc_active = in_load || busy_w;
  assign last_hit   = (addr == {page_q, last_off_q});

  pgwr_sequencer #(
    .WINDOW_CYC(WINDOW_CYC),
    .PROG_CYC  (PROG_CYC),
    .PAGE_BITS (PAGE_BITS)
  ) i_seq (
    .clk       (clk),
    .rst       (rst),
    .ld_en     (ld_en),
    .in_load   (in_load),
    .busy      (busy_w),
    .commit_en (commit_en),
    .commit_idx(commit_idx),
    .prog_done (prog_done)
  );

  pgwr_page_latch #(
    .PAGE_BITS(PAGE_BITS),
    .DATA_W   (DATA_W)
  ) i_latch (
    .clk    (clk),
    .rst    (rst),
    .ld_en  (ld_en),
    .ld_idx (addr[PAGE_BITS-1:0]),
    .ld_data(wdata),
    .clr    (prog_done),
    .rd_idx (commit_idx),
    .rd_data(lat_data),
    .rd_vld (lat_vld)
  );

  assign arr_we = commit_en && lat_vld;

  pgwr_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_array (
    .clk  (clk),
    .rst  (rst),
    .we   (arr_we),
    .waddr({page_q, commit_idx}),
    .wdata(lat_data),
    .re   (rd_en),
    .raddr(addr),
    .rq   (ram_q)
  );

  // page capture on first strobe, last-written tracking on every strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q      <= '0;
      last_off_q  <= '0;
      last_data_q <= '0;
    end else if (ld_en) begin
      if (!in_load) page_q <= addr[ADDR_W-1:PAGE_BITS];
      last_off_q  <= addr[PAGE_BITS-1:0];
      last_data_q <= wdata;
    end
  end

  // read-side status, aligned with the array's registered read
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q  <= 1'b0;
      poll_q      <= 1'b0;
      blank_q     <= 1'b0;
      poll_byte_q <= '0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) begin
        poll_q      <= cyc_active && last_hit;
        blank_q     <= cyc_active && !last_hit;
        poll_byte_q <= {~last_data_q[DATA_W-1], last_data_q[DATA_W-2:0]};
      end
    end
  end

  assign rdata    = poll_q ? poll_byte_q : (blank_q ? '1 : ram_q);
  assign rd_valid = rd_valid_q;
  assign busy     = busy_w;

  AST_COMMIT_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy_w); // R5
  AST_BUSY_FREEZES_LOAD: assert property (@(posedge clk) disable iff (rst)
    busy_w |=> $stable(page_q) && $stable(last_off_q) && $stable(last_data_q)); // R7
  AST_POLL_BIT7: assert property (@(posedge clk) disable iff (rst)
    rd_valid && poll_q |-> rdata[DATA_W-1] == ~$past(last_data_q[DATA_W-1])); // R8
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R11
endmodule

// File: tb/test_pgwr_engine.sv
module test_pgwr_engine;
  localparam int ADDR_W = 10;
  localparam int WIN    = 16;
  localparam int PRG    = 80;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic              rd_valid;
  logic              busy;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int last_strobe = 0;
  int rise_cyc = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  pgwr_engine #(
    .ADDR_W(ADDR_W), .PAGE_BITS(6), .WINDOW_CYC(WIN), .PROG_CYC(PRG)
  ) i_pgwr_engine (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .busy(busy)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever read data is presented
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected rd_valid", 1, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata == e, t, rdata, e);
      end
    end
  end

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    last_strobe = cyc;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_busy_rise();
    while (!busy) @(negedge clk);
    check(cyc - last_strobe == WIN, "R3 window length", cyc - last_strobe, WIN);
    rise_cyc = cyc;
  endtask

  task automatic wait_busy_fall();
    while (busy) @(negedge clk);
    check(cyc - rise_cyc == PRG, "R4 programming length", cyc - rise_cyc, PRG);
  endtask

  initial begin
    automatic logic [7:0] pa [6] = '{8'h11, 8'h92, 8'h33, 8'hC4, 8'h25, 8'hB6};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
    check(rdata == 8'h00, "R1 rdata after reset", rdata, 0);

    // Phase A: burst of six bytes into page 2 (0x080..0x085)
    for (int i = 0; i < 6; i++) do_write(10'h080 + 10'(i), pa[i]);
    do_read(10'h085, 8'h36, "R8 poll in window");
    do_read(10'h081, 8'hFF, "R9 other addr in window");
    wait_busy_rise();
    wait_busy_fall();
    for (int i = 0; i < 6; i++) do_read(10'h080 + 10'(i), pa[i], "R10 readback page A");

    // Phase B: spaced strobes retrigger the window, overwrite, foreign upper bits
    do_write(10'h081, 8'h5A);
    repeat (WIN - 2) @(negedge clk);
    check(busy == 1'b0, "R3 retrigger keeps busy low", busy, 0);
    do_write(10'h083, 8'h01);
    repeat (WIN - 2) @(negedge clk);
    check(busy == 1'b0, "R3 retrigger keeps busy low 2", busy, 0);
    do_write(10'h143, 8'hE7);                 // upper bits ignored: page 2, offset 3 (R2)
    do_read(10'h083, 8'h67, "R2 R8 poll via captured page");
    do_read(10'h143, 8'hFF, "R2 R9 foreign page reads blank");
    wait_busy_rise();
    do_read(10'h083, 8'h67, "R8 poll during programming");
    do_read(10'h080, 8'hFF, "R9 other addr during programming");
    do_write(10'h084, 8'h99);                 // ignored (R7)
    do_read(10'h083, 8'h67, "R7 last-written unchanged by busy strobe");
    wait_busy_fall();
    do_read(10'h080, 8'h11, "R5 unloaded offset kept");
    do_read(10'h081, 8'h5A, "R10 new byte");
    do_read(10'h082, 8'h33, "R5 unloaded offset kept 2");
    do_read(10'h083, 8'hE7, "R6 later load wins");
    do_read(10'h084, 8'h25, "R7 busy strobe ignored");
    do_read(10'h085, 8'hB6, "R5 unloaded offset kept 3");

    // Phase C: one byte at top offset, new cycle right after previous
    do_write(10'h03F, 8'h3C);
    do_read(10'h03F, 8'hBC, "R8 poll bit7 zero to one");
    wait_busy_rise();
    wait_busy_fall();                         // R4 single byte same length
    do_read(10'h03F, 8'h3C, "R10 true data after done");
    do_read(10'h080, 8'h11, "R11 idle read latency");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule